// File: doc/BRIEF.md
# Dual Watchpoint and Breakpoint Debug Comparator

This block watches the processor bus and stops the core when a programmed condition is met. It has two identical comparator units. Each unit holds an address value and mask and a data value and mask. Each unit can act in one of two modes:

- **Instruction breakpoint:** it matches only on instruction fetch cycles.
- **Data watchpoint:** it matches only on data transfer cycles.

An external debug-request pin, which may change at any time, can also stop the core. That pin passes through a two-flop synchroniser first.

Any match or request sets a sticky halt output. A status register records every cause that has occurred. Writing the control register clears both the halt flag and the status register.

All registers are loaded and read through a serial scan frame. The frame is shifted in one bit per clock while a shift enable is high. An update strobe then applies it. A test access port controller outside this block drives the shift enable, the serial data and the update strobe.

Top module: `watch_break_unit`

## Requirements
- R1: After reset, `halt` is 0, the status register reads 0, and every unit register reads 0, so both units are disabled.
- R2: A scan frame is 38 bits, shifted LSB first while `scan_shift` is high. Frame bits [4:0] are the register address, bit 5 is 1 for a write, and bits [37:6] are the value. The frame is applied in the cycle `scan_update` is high. A read frame loads the addressed register's contents into frame bits [37:6]. `scan_out` always shows frame bit 0, so these bits leave on `scan_out` while the next frame is shifted in.
- R3: A unit in breakpoint mode (unit control bit1 = 0) matches only when `bus_valid` and `bus_fetch` are both 1. `halt` is 1 in the cycle after the matching bus cycle.
- R4: A unit in watchpoint mode (unit control bit1 = 1) matches only when `bus_valid` is 1 and `bus_fetch` is 0.
- R5: A match needs the address and the data to equal the unit's values in every bit whose mask bit is 0. A mask bit of 1 makes that bit a don't-care.
- R6: A unit whose enable bit (unit control bit0) is 0 never matches.
- R7: `halt` stays 1 until a write to the control register (address 0). A write to address 0 clears `halt` whatever value it carries. Reads and writes to other registers leave `halt` unchanged.
- R8: The status register (address 1, also returned on a read of address 0) holds sticky cause bits and reflects `halt`:
  - bit0: unit 0 has matched
  - bit1: unit 1 has matched
  - bit2: an external request has arrived
  - bit3: the current value of `halt`
  
  A control write clears bits 0 to 2.
- R9: `dbg_req` is synchronised through two flops. If the pin is first sampled high at edge n, `halt` is set by edge n+2 and status bit2 is set with it.
- R10: If a match or request falls in the same cycle as a control-register write, the new event wins. `halt` stays 1, and the status register shows only the causes of that cycle.
- R11: Unit k's registers sit at address 8·(k+1) plus a field offset:
  - +0: address value
  - +1: address mask
  - +2: data value
  - +3: data mask
  - +4: control (bit0 enable, bit1 mode)

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_shift | input | 1 | Shift the scan frame one bit |
| scan_in | input | 1 | Serial data in, LSB first |
| scan_update | input | 1 | Apply the shifted frame |
| scan_out | output | 1 | Serial data out (frame bit 0) |
| bus_valid | input | 1 | A bus cycle is present |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data transfer |
| bus_addr | input | 32 | Bus address |
| bus_data | input | 32 | Bus data or instruction word |
| dbg_req | input | 1 | External debug request, not synchronised to `clk` |
| halt | output | 1 | Sticky request to enter debug state |

## Verification
A new halt cause and the control-register clear can fall in the same cycle. The bench provokes this by driving a matching bus cycle to unit 1 in exactly the cycle whose update strobe applies the clearing write, while a cause from unit 0 is still recorded. It then judges the outcome by three observations: `halt` is still 1, and a status read over the scan chain shows the unit 1 bit set and the unit 0 bit gone.

// File: rtl/wbu_pkg.sv
// Shared constants and types for the watchpoint/breakpoint comparator.
// Assumes a 32-bit bus and a 5-bit register address in each scan frame.
package wbu_pkg;
    localparam int BUS_W    = 32;
    localparam int REG_AW   = 5;
    localparam int FIELD_AW = 3;
    localparam int FRAME_W  = REG_AW + 1 + BUS_W;

    localparam logic [REG_AW-1:0] RA_CTRL = 5'd0;
    localparam logic [REG_AW-1:0] RA_STAT = 5'd1;

    localparam logic [FIELD_AW-1:0] F_AVAL  = 3'd0;
    localparam logic [FIELD_AW-1:0] F_AMASK = 3'd1;
    localparam logic [FIELD_AW-1:0] F_DVAL  = 3'd2;
    localparam logic [FIELD_AW-1:0] F_DMASK = 3'd3;
    localparam logic [FIELD_AW-1:0] F_UCTL  = 3'd4;

    typedef struct packed {
        logic [BUS_W-1:0] aval;
        logic [BUS_W-1:0] amask;
        logic [BUS_W-1:0] dval;
        logic [BUS_W-1:0] dmask;
        logic             wp;
        logic             en;
    } unit_cfg_t;
endpackage

// File: rtl/wbu_scan_port.sv
// Serial frame register: shifts LSB first, exposes the frame's address and
// value, and on update either signals a write or captures read data.
// Assumes shift and update are never high in the same cycle.
module wbu_scan_port
    import wbu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              ser_in,
    input  logic              update,
    input  logic [BUS_W-1:0]  rd_value,
    output logic              ser_out,
    output logic [REG_AW-1:0] frame_addr,
    output logic              wr_stb,
    output logic [BUS_W-1:0]  wr_value
);
    logic [FRAME_W-1:0] sr;

    // Shift register: update of a read frame loads data, shift moves one bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr <= '0;
        else if (update && !sr[REG_AW])
            sr <= {rd_value, sr[REG_AW:0]};
        else if (shift_en)
            sr <= {ser_in, sr[FRAME_W-1:1]};
    end

    assign frame_addr = sr[REG_AW-1:0];
    assign wr_stb     = update & sr[REG_AW];
    assign wr_value   = sr[FRAME_W-1:REG_AW+1];
    assign ser_out    = sr[0];
endmodule

// File: rtl/wbu_match_unit.sv
// One comparator unit: holds its value/mask/control registers and flags a
// hit when an enabled unit sees a bus cycle of its kind whose unmasked
// address and data bits all agree. Assumes one write strobe per cycle.
module wbu_match_unit
    import wbu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [FIELD_AW-1:0] wr_field,
    input  logic [BUS_W-1:0]    wr_value,
    input  logic                bus_valid,
    input  logic                bus_fetch,
    input  logic [BUS_W-1:0]    bus_addr,
    input  logic [BUS_W-1:0]    bus_data,
    output unit_cfg_t           cfg,
    output logic                hit
);
    logic addr_ok;
    logic data_ok;
    logic kind_ok;

    // Register file of the unit, written field by field from the scan port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (wr_field)
                F_AVAL:  cfg.aval  <= wr_value;
                F_AMASK: cfg.amask <= wr_value;
                F_DVAL:  cfg.dval  <= wr_value;
                F_DMASK: cfg.dmask <= wr_value;
                F_UCTL: begin
                    cfg.en <= wr_value[0];
                    cfg.wp <= wr_value[1];
                end
                default: ;
            endcase
        end
    end

    // Masked compare and cycle-kind selection.
    always_comb begin
        addr_ok = ((bus_addr ^ cfg.aval) & ~cfg.amask) == '0;
        data_ok = ((bus_data ^ cfg.dval) & ~cfg.dmask) == '0;
        kind_ok = cfg.wp ? !bus_fetch : bus_fetch;
        hit     = cfg.en && bus_valid && kind_ok && addr_ok && data_ok;
    end
endmodule

// File: rtl/wbu_req_sync.sv
// Multi-flop synchroniser for the external debug request pin.
// Assumes the pin is held long enough to be seen at the clock.
module wbu_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Stage s of the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n)
                chain[s] <= 1'b0;
            else
                chain[s] <= (s == 0) ? async_in : chain[(s == 0) ? 0 : s-1];
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/wbu_halt_ctrl.sv
// Sticky halt flag and cause bits. A clear and a new event in the same
// cycle leave only the new event recorded.
module wbu_halt_ctrl #(
    parameter int NEV = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] events,
    input  logic           clr,
    output logic           halt,
    output logic [NEV-1:0] causes
);
    // Record causes and keep halt until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt   <= 1'b0;
            causes <= '0;
        end else if (clr) begin
            halt   <= |events;
            causes <= events;
        end else begin
            halt   <= halt | (|events);
            causes <= causes | events;
        end
    end
endmodule

// File: rtl/watch_break_unit.sv
// Top of the debug comparator: scan port, N comparator units, request
// synchroniser and halt/status logic. Assumes the units fit the address map
// at 8*(k+1), so N_UNITS is at most 3 with a 5-bit register address.
module watch_break_unit
    import wbu_pkg::*;
#(
    parameter int N_UNITS     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_shift,
    input  logic             scan_in,
    input  logic             scan_update,
    output logic             scan_out,
    input  logic             bus_valid,
    input  logic             bus_fetch,
    input  logic [BUS_W-1:0] bus_addr,
    input  logic [BUS_W-1:0] bus_data,
    input  logic             dbg_req,
    output logic             halt
);
    localparam int NEV = N_UNITS + 1;
    localparam int UW  = REG_AW - FIELD_AW;

    logic [REG_AW-1:0] frame_addr;
    logic              wr_stb;
    logic [BUS_W-1:0]  wr_value;
    logic [BUS_W-1:0]  rd_value;
    unit_cfg_t         cfgs [N_UNITS];
    logic [N_UNITS-1:0] hits;
    logic [N_UNITS-1:0] unit_en;
    logic [N_UNITS-1:0] unit_wp;
    logic              req_sync;
    logic [NEV-1:0]    events;
    logic [NEV-1:0]    status;
    logic              ctrl_clr;

    wbu_scan_port u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (scan_shift),
        .ser_in     (scan_in),
        .update     (scan_update),
        .rd_value   (rd_value),
        .ser_out    (scan_out),
        .frame_addr (frame_addr),
        .wr_stb     (wr_stb),
        .wr_value   (wr_value)
    );

    for (genvar k = 0; k < N_UNITS; k++) begin : g_unit
        logic sel;
        assign sel = wr_stb && (frame_addr[REG_AW-1:FIELD_AW] == UW'(k + 1));

        wbu_match_unit u_match (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (sel),
            .wr_field  (frame_addr[FIELD_AW-1:0]),
            .wr_value  (wr_value),
            .bus_valid (bus_valid),
            .bus_fetch (bus_fetch),
            .bus_addr  (bus_addr),
            .bus_data  (bus_data),
            .cfg       (cfgs[k]),
            .hit       (hits[k])
        );

        assign unit_en[k] = cfgs[k].en;
        assign unit_wp[k] = cfgs[k].wp;
    end

    wbu_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (dbg_req),
        .sync_out (req_sync)
    );

    assign events   = {req_sync, hits};
    assign ctrl_clr = wr_stb && (frame_addr == RA_CTRL);

    wbu_halt_ctrl #(.NEV(NEV)) u_halt (
        .clk    (clk),
        .rst_n  (rst_n),
        .events (events),
        .clr    (ctrl_clr),
        .halt   (halt),
        .causes (status)
    );

    // Read-back multiplexer for the addressed register.
    always_comb begin
        rd_value = '0;
        if (frame_addr == RA_CTRL || frame_addr == RA_STAT) begin
            rd_value[NEV-1:0] = status;
            rd_value[NEV]     = halt;
        end
        for (int k = 0; k < N_UNITS; k++) begin
            if (frame_addr[REG_AW-1:FIELD_AW] == UW'(k + 1)) begin
                case (frame_addr[FIELD_AW-1:0])
                    F_AVAL:  rd_value = cfgs[k].aval;
                    F_AMASK: rd_value = cfgs[k].amask;
                    F_DVAL:  rd_value = cfgs[k].dval;
                    F_DMASK: rd_value = cfgs[k].dmask;
                    F_UCTL:  rd_value = {{(BUS_W-2){1'b0}}, cfgs[k].wp, cfgs[k].en};
                    default: rd_value = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/wbu_checker.sv
// Property checker for watch_break_unit, attached by bind below.
module wbu_checker #(
    parameter int N_UNITS = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               halt,
    input logic               ctrl_clr,
    input logic [N_UNITS:0]   events,
    input logic [N_UNITS-1:0] hits,
    input logic [N_UNITS-1:0] unit_en,
    input logic [N_UNITS-1:0] unit_wp,
    input logic               bus_valid,
    input logic               bus_fetch,
    input logic               dbg_req,
    input logic               req_sync,
    input logic [N_UNITS:0]   status
);
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) halt && !ctrl_clr |=> halt); // R7
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n) ctrl_clr && (events == '0) |=> !halt); // R7
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n) (|events) |=> halt); // R10
    AST_CAUSE_IMPLIES_HALT: assert property (@(posedge clk) disable iff (!rst_n) (|status) |-> halt); // R8
    AST_REQ_TWO_FLOPS: assert property (@(posedge clk) disable iff (!rst_n) req_sync |-> $past(dbg_req, 2)); // R9

    for (genvar k = 0; k < N_UNITS; k++) begin : g_unit_chk
        AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !unit_en[k] |-> !hits[k]); // R6
        AST_BP_FETCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n) hits[k] && !unit_wp[k] |-> bus_valid && bus_fetch); // R3
        AST_WP_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n) hits[k] && unit_wp[k] |-> bus_valid && !bus_fetch); // R4
    end
endmodule

bind watch_break_unit wbu_checker #(.N_UNITS(N_UNITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt      (halt),
    .ctrl_clr  (ctrl_clr),
    .events    (events),
    .hits      (hits),
    .unit_en   (unit_en),
    .unit_wp   (unit_wp),
    .bus_valid (bus_valid),
    .bus_fetch (bus_fetch),
    .dbg_req   (dbg_req),
    .req_sync  (req_sync),
    .status    (status)
);

// File: tb/sim_watch_break_unit.sv
module sim_watch_break_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_shift = 1'b0;
    logic        scan_in = 1'b0;
    logic        scan_update = 1'b0;
    logic        scan_out;
    logic        bus_valid = 1'b0;
    logic        bus_fetch = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_data = '0;
    logic        dbg_req = 1'b0;
    logic        halt;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    watch_break_unit u0 (
        .clk(clk), .rst_n(rst_n), .scan_shift(scan_shift), .scan_in(scan_in),
        .scan_update(scan_update), .scan_out(scan_out), .bus_valid(bus_valid),
        .bus_fetch(bus_fetch), .bus_addr(bus_addr), .bus_data(bus_data),
        .dbg_req(dbg_req), .halt(halt)
    );

    typedef struct packed {
        logic        wp;
        logic [31:0] amask;
        logic [31:0] dmask;
        logic        fetch;
        logic [31:0] addr;
        logic [31:0] data;
        logic        exp;
    } vec_t;

    // Unit 0 holds address 0x1000 and data 0xCAFE0000 for all vectors.
    localparam vec_t VEC [8] = '{
        '{1'b0, 32'h0, 32'h0,    1'b1, 32'h1000, 32'hCAFE0000, 1'b1}, // R3 fetch hit
        '{1'b0, 32'h0, 32'h0,    1'b0, 32'h1000, 32'hCAFE0000, 1'b0}, // R3 data ignored
        '{1'b1, 32'h0, 32'h0,    1'b0, 32'h1000, 32'hCAFE0000, 1'b1}, // R4 data hit
        '{1'b1, 32'h0, 32'h0,    1'b1, 32'h1000, 32'hCAFE0000, 1'b0}, // R4 fetch ignored
        '{1'b1, 32'h0, 32'h0,    1'b0, 32'h1004, 32'hCAFE0000, 1'b0}, // R5 addr miss
        '{1'b1, 32'hF, 32'h0,    1'b0, 32'h100C, 32'hCAFE0000, 1'b1}, // R5 addr mask
        '{1'b0, 32'h0, 32'h0,    1'b1, 32'h1000, 32'hCAFE0001, 1'b0}, // R5 data miss
        '{1'b0, 32'h0, 32'hFFFF, 1'b1, 32'h1000, 32'hCAFE1234, 1'b1}  // R5 data mask
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Shift one frame, apply it; optional bus cycle in the update cycle.
    task automatic frame(input logic [4:0] a, input logic w, input logic [31:0] v,
                         input logic pulse, input logic pf, input logic [31:0] pa,
                         input logic [31:0] pd, output logic [31:0] cap);
        logic [37:0] fr;
        logic [37:0] c;
        fr = {v, w, a};
        for (int i = 0; i < 38; i++) begin
            @(negedge clk);
            c[i] = scan_out;
            scan_in = fr[i];
            scan_shift = 1'b1;
        end
        @(negedge clk);
        scan_shift = 1'b0;
        scan_update = 1'b1;
        if (pulse) begin
            bus_valid = 1'b1; bus_fetch = pf; bus_addr = pa; bus_data = pd;
        end
        @(negedge clk);
        scan_update = 1'b0;
        bus_valid = 1'b0;
        cap = c[37:6];
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        logic [31:0] d;
        frame(a, 1'b1, v, 1'b0, 1'b0, 32'h0, 32'h0, d);
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        logic [31:0] d;
        frame(a, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, d);
        frame(5'd1, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, v);
    endtask

    // One bus cycle; halt sampled after the capturing edge.
    task automatic bus_cycle(input logic f, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_fetch = f; bus_addr = a; bus_data = d;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 halt", {31'b0, halt}, 32'h0);
        rd(5'd1, v);  chk("R1 status", v, 32'h0);
        rd(5'd12, v); chk("R1 unit0 ctrl", v, 32'h0);
        rd(5'd16, v); chk("R1 unit1 aval", v, 32'h0);

        // R2 R11 write and read back through the frame
        wr(5'd8, 32'h0000_1000);
        wr(5'd10, 32'hCAFE_0000);
        rd(5'd8, v);  chk("R2 R11 unit0 aval", v, 32'h0000_1000);
        rd(5'd10, v); chk("R2 R11 unit0 dval", v, 32'hCAFE_0000);

        // Vector table: R3 R4 R5
        foreach (VEC[i]) begin
            wr(5'd9, VEC[i].amask);
            wr(5'd11, VEC[i].dmask);
            wr(5'd12, {30'b0, VEC[i].wp, 1'b1});
            bus_cycle(VEC[i].fetch, VEC[i].addr, VEC[i].data);
            chk($sformatf("R3/R4/R5 vector %0d halt", i), {31'b0, halt}, {31'b0, VEC[i].exp});
            wr(5'd0, 32'h0);
            chk($sformatf("R7 vector %0d cleared", i), {31'b0, halt}, 32'h0);
        end

        // R6 disabled unit does not match
        wr(5'd9, 32'h0); wr(5'd11, 32'h0);
        wr(5'd12, 32'h0);
        bus_cycle(1'b1, 32'h1000, 32'hCAFE0000);
        chk("R6 disabled no halt", {31'b0, halt}, 32'h0);
        rd(5'd1, v); chk("R6 status empty", v, 32'h0);

        // R7 R8 sticky halt and cause
        wr(5'd12, 32'h1);
        bus_cycle(1'b1, 32'h1000, 32'hCAFE0000);
        repeat (5) @(negedge clk);
        chk("R7 sticky", {31'b0, halt}, 32'h1);
        rd(5'd1, v); chk("R8 status unit0", v, 32'h9);
        wr(5'd9, 32'h0);
        chk("R7 other write keeps halt", {31'b0, halt}, 32'h1);

        // R10 clear and unit1 watchpoint hit in the same cycle
        wr(5'd16, 32'h2000); wr(5'd18, 32'h55); wr(5'd20, 32'h3);
        chk("R10 halt before", {31'b0, halt}, 32'h1);
        frame(5'd0, 1'b1, 32'h0, 1'b1, 1'b0, 32'h2000, 32'h55, v);
        chk("R10 halt kept", {31'b0, halt}, 32'h1);
        rd(5'd0, v); chk("R10 R8 status only unit1", v, 32'hA);
        wr(5'd0, 32'h0);
        rd(5'd1, v); chk("R7 status cleared", v, 32'h0);

        // R9 request latency through two flops
        @(negedge clk); dbg_req = 1'b1;
        @(negedge clk); chk("R9 edge1", {31'b0, halt}, 32'h0);
        @(negedge clk); chk("R9 edge2", {31'b0, halt}, 32'h0);
        @(negedge clk); chk("R9 edge3", {31'b0, halt}, 32'h1);
        dbg_req = 1'b0;
        repeat (4) @(negedge clk);
        rd(5'd1, v); chk("R9 R8 status ext", v, 32'hC);
        wr(5'd0, 32'h0);
        chk("R7 final clear", {31'b0, halt}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule